// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block sits between a 36-bit long-word path and an external port of a different width. In the splitting direction it takes one long word and hands it out as two 18-bit halves or four 9-bit bytes. In the packing direction it collects two halves or four bytes and hands out one long word. A pass-through setting moves 36-bit words unchanged through a single register stage. Both sides use a valid/ready handshake. Narrow pieces always travel on the low bits of the 36-bit data buses.

The width ratio and the byte order are not parameters. They come from two strap inputs that are sampled on every clock edge while `rst_n` is low. They are then frozen until the next reset, so one netlist serves every bus arrangement.

Control is a four-state machine:
- `ST_EMPTY` holds nothing. A piece or word accepted here moves it to `ST_GATHER` when packing, or to `ST_SPLIT` otherwise.
- `ST_SPLIT` presents pieces of the held word. After the last piece it returns to `ST_EMPTY`, or stays in `ST_SPLIT` when a new word arrives in the same cycle.
- `ST_GATHER` collects pieces and moves to `ST_DONE` when the last piece lands.
- `ST_DONE` presents the packed word. It then returns to `ST_EMPTY`, or goes back to `ST_GATHER` when the first piece of the next word arrives in the same cycle.

Reset returns the machine to `ST_EMPTY` from any state.

Top module: `lane_width_adapter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. A partly packed long word held at reset is discarded and never appears at the output.
- R2: The straps are sampled only while `rst_n` is 0. Changing them after reset release has no effect on conversion until the next reset.
- R3: `width_strap` encodes the conversion:
  - 000 is 36 to 36;
  - 001 is 36 to 18;
  - 010 is 36 to 9;
  - 011 is 18 to 36;
  - 100 is 9 to 36;
  - 101, 110 and 111 act as 36 to 36.
- R4: The 18-bit lanes are [35:18] and [17:0]. The 9-bit lanes are [35:27], [26:18], [17:9] and [8:0]. A narrow piece uses the low bits of `in_data`/`out_data`: the unused input bits are ignored and the unused output bits are 0.
- R5: With `order_strap` 0 at reset, the most significant lane is transferred first.
- R6: With `order_strap` 1 at reset, the least significant lane is transferred first.
- R7: When splitting, each piece takes its own output handshake. A new long word is accepted only in the cycle the last piece leaves, and that cycle has no bubble.
- R8: When packing, the long word becomes valid in the cycle after its last piece is accepted, never earlier. In `ST_DONE`, `in_ready` follows `out_ready`.
- R9: In 36 to 36, a word accepted at a clock edge is presented on the next cycle. `in_ready` is 1 when the stage is empty or `out_ready` is 1.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while it is low |
| width_strap | input | 3 | Conversion select strap (R3) |
| order_strap | input | 1 | 0: most significant lane first; 1: least significant lane first |
| in_valid | input | 1 | Input piece or word valid |
| in_ready | output | 1 | Input accepted when high together with in_valid |
| in_data | input | 36 | Input data; narrow pieces on the low bits |
| out_valid | output | 1 | Output piece or word valid |
| out_ready | input | 1 | Downstream accepts when high together with out_valid |
| out_data | output | 36 | Output data; narrow pieces on the low bits, upper bits 0 |

## Verification
The hardest situation to reach is a half-packed word caught by reset. The machine must be in `ST_GATHER` with its counter part-way, and reset must then arrive. After that, a full new word must come out clean. The bench forces this with directed steps: it feeds two of four bytes, pulls reset, and then drives four fresh bytes. The bench model expects only the fresh bytes.

A second hard case is a strap change after reset, which from the ports looks like a silent reconfiguration. The bench changes both straps mid-run and keeps its model on the values that were sampled during reset.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
    localparam int MAX_LOG = 2;                    // up to 2**MAX_LOG pieces per long word
    localparam int LOG_W   = $clog2(MAX_LOG + 1);  // width of the ratio exponent field

    typedef struct packed {
        logic             is_pack;    // narrow in, long out
        logic [LOG_W-1:0] pieces_log; // log2(pieces per long word)
        logic             lsb_first;  // ordering of lanes
    } lwa_cfg_t;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_SPLIT  = 2'd1,
        ST_GATHER = 2'd2,
        ST_DONE   = 2'd3
    } lwa_state_t;
endpackage

// File: rtl/lwa_strap_cfg.sv
module lwa_strap_cfg
    import lwa_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     width_strap,
    input  logic           order_strap,
    output lwa_cfg_t       cfg
);
    lwa_cfg_t decoded;

    always_comb begin
        decoded           = '0;
        decoded.lsb_first = order_strap;
        case (width_strap)
            3'b001:  begin decoded.is_pack = 1'b0; decoded.pieces_log = LOG_W'(1); end
            3'b010:  begin decoded.is_pack = 1'b0; decoded.pieces_log = LOG_W'(2); end
            3'b011:  begin decoded.is_pack = 1'b1; decoded.pieces_log = LOG_W'(1); end
            3'b100:  begin decoded.is_pack = 1'b1; decoded.pieces_log = LOG_W'(2); end
            default: begin decoded.is_pack = 1'b0; decoded.pieces_log = '0;        end
        endcase
    end

    // Straps are captured only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= decoded;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg)); // R2
endmodule

// File: rtl/lwa_lane_mux.sv
module lwa_lane_mux
    import lwa_pkg::*;
#(
    parameter int LONG_W = 36
) (
    input  logic [LONG_W-1:0]  word_in,
    input  logic [LONG_W-1:0]  piece_in,
    input  logic [LOG_W-1:0]   pieces_log,
    input  logic [MAX_LOG-1:0] lane,
    output logic [LONG_W-1:0]  piece_out,
    output logic [LONG_W-1:0]  word_ins
);
    localparam int SHW = $clog2(LONG_W) + 1;

    logic [SHW-1:0]    piece_w;
    logic [SHW-1:0]    shamt;
    logic [LONG_W-1:0] mask;

    always_comb begin
        piece_w   = SHW'(LONG_W) >> pieces_log;
        // lane 0 is the most significant slice of the long word
        shamt     = SHW'(LONG_W) - (SHW'(lane) + SHW'(1)) * piece_w;
        mask      = ~({LONG_W{1'b1}} << piece_w);
        piece_out = (word_in >> shamt) & mask;
        word_ins  = (word_in & ~(mask << shamt)) | ((piece_in & mask) << shamt);
    end
endmodule

// File: rtl/lwa_fsm.sv
module lwa_fsm
    import lwa_pkg::*;
#(
    parameter int LONG_W = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lwa_cfg_t           cfg,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LONG_W-1:0]  in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LONG_W-1:0]  out_data,
    output logic [LONG_W-1:0]  mux_word,
    output logic [MAX_LOG-1:0] mux_lane,
    input  logic [LONG_W-1:0]  mux_piece,
    input  logic [LONG_W-1:0]  mux_ins
);
    lwa_state_t         state_q, state_n;
    logic [MAX_LOG-1:0] cnt_q, cnt_n;
    logic [LONG_W-1:0]  hold_q, hold_n;
    logic [MAX_LOG:0]   npieces;
    logic [MAX_LOG-1:0] last_idx;
    logic               last, in_fire, out_fire;

    always_comb begin
        npieces  = (MAX_LOG+1)'(1) << cfg.pieces_log;
        last_idx = MAX_LOG'(npieces - (MAX_LOG+1)'(1));
        last     = (cnt_q == last_idx);
        in_fire  = in_valid & in_ready;
        out_fire = out_valid & out_ready;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            hold_q  <= hold_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        hold_n  = hold_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_fire) begin
                    if (cfg.is_pack) begin
                        hold_n  = mux_ins;
                        cnt_n   = MAX_LOG'(1);
                        state_n = ST_GATHER;
                    end else begin
                        hold_n  = in_data;
                        cnt_n   = '0;
                        state_n = ST_SPLIT;
                    end
                end
            end
            ST_SPLIT: begin
                if (out_fire) begin
                    if (last) begin
                        cnt_n = '0;
                        if (in_fire) hold_n  = in_data;
                        else         state_n = ST_EMPTY;
                    end else begin
                        cnt_n = cnt_q + MAX_LOG'(1);
                    end
                end
            end
            ST_GATHER: begin
                if (in_fire) begin
                    hold_n = mux_ins;
                    if (last) begin
                        cnt_n   = '0;
                        state_n = ST_DONE;
                    end else begin
                        cnt_n = cnt_q + MAX_LOG'(1);
                    end
                end
            end
            ST_DONE: begin
                if (out_fire) begin
                    if (in_fire) begin
                        hold_n  = mux_ins;
                        cnt_n   = MAX_LOG'(1);
                        state_n = ST_GATHER;
                    end else begin
                        cnt_n   = '0;
                        state_n = ST_EMPTY;
                    end
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY:  in_ready = 1'b1;
            ST_SPLIT:  begin out_valid = 1'b1; in_ready = last & out_ready; end
            ST_GATHER: in_ready = 1'b1;
            ST_DONE:   begin out_valid = 1'b1; in_ready = out_ready; end
        endcase
        out_data = cfg.is_pack ? hold_q : mux_piece;
        mux_word = (!cfg.is_pack || state_q == ST_GATHER) ? hold_q : '0;
        mux_lane = cfg.lsb_first ? (last_idx - cnt_q) : cnt_q;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
    AST_PACK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.is_pack && $rose(out_valid) |-> $past(in_valid && in_ready)); // R8
    AST_PASS_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.is_pack && cfg.pieces_log == '0 && in_valid && in_ready
        |=> out_valid && out_data == $past(in_data)); // R9
    AST_SPLIT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.is_pack && out_valid && !out_ready |-> !in_ready); // R7
endmodule

// File: rtl/lane_width_adapter.sv
module lane_width_adapter
    import lwa_pkg::*;
#(
    parameter int LONG_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        width_strap,
    input  logic              order_strap,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LONG_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [LONG_W-1:0] out_data
);
    lwa_cfg_t           cfg;
    logic [LONG_W-1:0]  mux_word, mux_piece, mux_ins;
    logic [MAX_LOG-1:0] mux_lane;

    lwa_strap_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .width_strap (width_strap),
        .order_strap (order_strap),
        .cfg         (cfg)
    );

    lwa_lane_mux #(.LONG_W(LONG_W)) u_mux (
        .word_in    (mux_word),
        .piece_in   (in_data),
        .pieces_log (cfg.pieces_log),
        .lane       (mux_lane),
        .piece_out  (mux_piece),
        .word_ins   (mux_ins)
    );

    lwa_fsm #(.LONG_W(LONG_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .mux_word  (mux_word),
        .mux_lane  (mux_lane),
        .mux_piece (mux_piece),
        .mux_ins   (mux_ins)
    );
endmodule

// File: tb/lane_width_adapter_tb.sv
module lane_width_adapter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  width_strap = 3'b000;
    logic        order_strap = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [35:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [35:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state
    bit          m_pack;
    int          m_n;
    bit          m_lsb;
    logic [35:0] pend[$];
    logic [35:0] acc;
    int          got;
    bit          have;
    logic [35:0] done_word;

    always #5 clk = ~clk;

    lane_width_adapter u_dut (
        .clk(clk), .rst_n(rst_n), .width_strap(width_strap), .order_strap(order_strap),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // R3 strap encoding, computed from the requirement
    task automatic set_model(input logic [2:0] ws, input bit os);
        case (ws)
            3'b001:  begin m_pack = 0; m_n = 2; end
            3'b010:  begin m_pack = 0; m_n = 4; end
            3'b011:  begin m_pack = 1; m_n = 2; end
            3'b100:  begin m_pack = 1; m_n = 4; end
            default: begin m_pack = 0; m_n = 1; end
        endcase
        m_lsb = os;
        pend.delete();
        acc = '0; got = 0; have = 0; done_word = '0;
    endtask

    function automatic int lane_shift(input int k);
        int w, lane;
        w    = 36 / m_n;
        lane = m_lsb ? (m_n - 1 - k) : k;
        return 36 - (lane + 1) * w;
    endfunction

    function automatic logic [35:0] piece_mask();
        int w;
        w = 36 / m_n;
        return (w == 36) ? 36'hF_FFFF_FFFF : ((36'd1 << w) - 36'd1);
    endfunction

    task automatic check(input string tag, input string what, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit iv, input logic [35:0] d, input bit ordy);
        bit ev, er, fin, fout;
        logic [35:0] ed;
        @(negedge clk);
        in_valid = iv; in_data = d; out_ready = ordy;
        #1;
        if (!m_pack) begin
            ev = pend.size() > 0;
            er = (pend.size() == 0) || (pend.size() == 1 && ordy);
            ed = ev ? pend[0] : '0;
        end else begin
            ev = have;
            er = !have || ordy;
            ed = done_word;
        end
        check(tag, "out_valid", {35'd0, out_valid}, {35'd0, ev});
        check(tag, "in_ready", {35'd0, in_ready}, {35'd0, er});
        if (ev) check(tag, "out_data", out_data, ed);
        fin  = iv && er;
        fout = ev && ordy;
        @(posedge clk);
        if (!m_pack) begin
            if (fout) void'(pend.pop_front());
            if (fin) for (int k = 0; k < m_n; k++)
                pend.push_back((d >> lane_shift(k)) & piece_mask());
        end else begin
            if (fout) have = 0;
            if (fin) begin
                acc = acc | ((d & piece_mask()) << lane_shift(got));
                got++;
                if (got == m_n) begin
                    done_word = acc; have = 1; acc = '0; got = 0;
                end
            end
        end
    endtask

    task automatic do_reset(input logic [2:0] ws, input bit os);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        width_strap = ws; order_strap = os;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_model(ws, os);
        #1;
        check("R1", "reset out_valid", {35'd0, out_valid}, 36'd0);
        check("R1", "reset in_ready", {35'd0, in_ready}, 36'd1);
    endtask

    task automatic run_random(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++)
            step(tag, ($urandom % 4) != 0, 36'({$urandom, $urandom}), ($urandom % 3) != 0);
    endtask

    initial begin
        do_reset(3'b000, 1'b0);
        run_random("R9", 300);
        step("R10", 1'b1, 36'h1_2345_6789, 1'b0);
        step("R10", 1'b0, 36'd0, 1'b0);
        step("R10", 1'b0, 36'd0, 1'b0);
        step("R10", 1'b0, 36'd0, 1'b1);

        do_reset(3'b001, 1'b0);
        run_random("R5", 300);
        do_reset(3'b010, 1'b0);
        step("R4", 1'b1, 36'hA_BCDE_F012, 1'b1);
        run_random("R7", 300);
        do_reset(3'b010, 1'b1);
        run_random("R6", 300);
        do_reset(3'b001, 1'b1);
        run_random("R7", 200);

        do_reset(3'b011, 1'b0);
        run_random("R8", 300);
        do_reset(3'b100, 1'b1);
        run_random("R4", 300);
        do_reset(3'b100, 1'b0);
        run_random("R8", 200);

        do_reset(3'b110, 1'b0);
        run_random("R3", 200);
        do_reset(3'b111, 1'b1);
        run_random("R3", 100);

        // R1: partial word dropped by reset
        do_reset(3'b100, 1'b0);
        step("R1", 1'b1, 36'h0_0000_0111, 1'b0);
        step("R1", 1'b1, 36'h0_0000_0122, 1'b0);
        do_reset(3'b100, 1'b0);
        step("R1", 1'b1, 36'hF_FFFF_FE01, 1'b1);
        step("R1", 1'b1, 36'h0_0000_0002, 1'b1);
        step("R1", 1'b1, 36'h0_0000_0003, 1'b1);
        step("R1", 1'b1, 36'h0_0000_0004, 1'b1);
        step("R1", 1'b0, 36'd0, 1'b1);

        // R2: strap changes after release are ignored
        do_reset(3'b010, 1'b1);
        width_strap = 3'b011; order_strap = 1'b0;
        run_random("R2", 300);
        do_reset(3'b011, 1'b0);
        width_strap = 3'b000; order_strap = 1'b1;
        run_random("R2", 300);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule